// File: doc/BRIEF.md
# Vector length configuration unit

This unit carries out the state update of a vector configuration instruction. Each cycle in which `cfg_valid` is high, it takes a requested element count (the application vector length), two flags that say whether the destination and source register specifiers are register zero, and a proposed vector type word. From these it decides whether the type word is legal for the configured vector register length and maximum element width. It computes the largest element count that the chosen grouping allows, then registers the new vector length, the new type word and the value for the destination register.

The type word layout used throughout is: bits [2:0] hold the register grouping code (values 0 to 3 select whole-register multipliers of 1, 2, 4 and 8; 5, 6 and 7 select 1/8, 1/4 and 1/2; 4 is reserved). Bits [5:3] hold the element width code, where the width in bits is 8 shifted left by the code. Bits [7:6] hold a divider field that must be zero. Bit XLEN-1 is the illegal flag, and every bit in between is reserved and must be zero. Instruction decoding, register-file access and moving the program counter on to the next instruction are done by the surrounding pipeline.

Top module: `vcfg_unit`

## Requirements
- R1: An element width code whose width (8 << code) exceeds ELEN makes the configuration illegal.
- R2: A grouping code of exactly 4 is reserved and makes the configuration illegal.
- R3: A fractional grouping code L (5, 6 or 7) is illegal when ELEN >> (8 - L) is less than the selected element width.
- R4: A set illegal bit (bit XLEN-1), a nonzero divider field (bits [7:6]) or any nonzero reserved bit (bits XLEN-2 down to 8) in the incoming type word makes the configuration illegal.
- R5: On an illegal configuration, the stored type word becomes only bit XLEN-1 set and the vector length becomes 0.
- R6: When both register specifiers are zero, the current vector length is used as the requested count. The new length is the smaller of the current length and the new maximum, so it is kept when it still fits.
- R7: When the source specifier is zero and the destination is not, the new vector length equals the maximum count.
- R8: On a legal configuration with a nonzero source specifier, the vector length becomes the smaller of the requested count and the maximum count, and the type word is stored exactly as supplied.
- R9: `rd_wdata` holds the newly written vector length, zero-extended, from the cycle after each accepted request.
- R10: Reset gives vector length 0, a type word with only bit XLEN-1 set, and a write-back value of 0. The outputs change only in the cycle after `cfg_valid` is high.
- R11: The maximum count equals VLEN times the grouping multiplier divided by the element width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_valid | input | 1 | Request strobe; one configuration per high cycle |
| avl_in | input | XLEN | Requested element count from the source register |
| rd_is_zero | input | 1 | Destination specifier is register zero |
| rs1_is_zero | input | 1 | Source specifier is register zero |
| vtype_in | input | XLEN | Proposed vector type word |
| vl_out | output | VLW | Current vector length register |
| vtype_out | output | XLEN | Current vector type register |
| rd_wdata | output | XLEN | Value to write to the destination register |

## Verification
The assertions assume that `cfg_valid` stays low while reset is held. They also assume that the request inputs seen by a property are the ones present in the cycle the strobe is sampled, so that `$past` of `avl_in` is the count that was actually requested. The bench drives every input at the falling edge and releases the strobe after each request, which keeps stimulus inside these assumptions. The random type words draw element width codes only up to 4 and mix in occasional corrupt divider, reserved and illegal bits. This way legal and illegal paths, both fractional and whole groupings, and the three specifier cases all occur many times.

// File: rtl/vcfg_pkg.sv
package vcfg_pkg;
  // Type word field positions (decoded by the legality check and VLMAX logic)
  localparam int LMUL_LSB  = 0;
  localparam int LMUL_W    = 3;
  localparam int SEW_LSB   = 3;
  localparam int SEW_W     = 3;
  localparam int DIV_LSB   = 6;
  localparam int DIV_W     = 2;
  localparam int RSV_LSB   = 8;

  typedef struct packed {
    logic [LMUL_W-1:0] lmul;
    logic [SEW_W-1:0]  sew;
    logic [DIV_W-1:0]  div;
  } vcfg_fields_t;

  function automatic vcfg_fields_t unpack_fields(input logic [RSV_LSB-1:0] low);
    vcfg_fields_t f;
    f.lmul = low[LMUL_LSB +: LMUL_W];
    f.sew  = low[SEW_LSB  +: SEW_W];
    f.div  = low[DIV_LSB  +: DIV_W];
    return f;
  endfunction
endpackage

// File: rtl/vcfg_legal_check.sv
module vcfg_legal_check
  import vcfg_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int ELEN = 64
) (
  input  logic [XLEN-1:0] vtype,
  output logic            illegal
);
  localparam int RSV_W = XLEN - 1 - RSV_LSB;

  vcfg_fields_t f;
  logic         rsv_bad;
  logic         width_bad;
  logic         frac_bad;

  assign f = unpack_fields(vtype[RSV_LSB-1:0]);

  generate
    if (RSV_W > 0) begin : g_rsv
      assign rsv_bad = |vtype[XLEN-2:RSV_LSB];
    end else begin : g_no_rsv
      assign rsv_bad = 1'b0;
    end
  endgenerate

  always_comb begin
    logic [31:0] sew_bits;
    logic [31:0] frac_cap;
    sew_bits  = 32'd8 << f.sew;
    width_bad = sew_bits > 32'(ELEN);
    frac_cap  = 32'(ELEN) >> (4'd8 - {1'b0, f.lmul});
    frac_bad  = 1'b0;
    if (f.lmul[2]) begin
      if (f.lmul == 3'd4) frac_bad = 1'b1;
      else if (frac_cap < sew_bits) frac_bad = 1'b1;
    end
  end

  assign illegal = width_bad | frac_bad | rsv_bad | (f.div != '0) | vtype[XLEN-1];
endmodule

// File: rtl/vcfg_vlmax_calc.sv
module vcfg_vlmax_calc
  import vcfg_pkg::*;
#(
  parameter int VLEN = 128,
  parameter int VLW  = 11
) (
  input  logic [LMUL_W-1:0] lmul,
  input  logic [SEW_W-1:0]  sew,
  output logic [VLW-1:0]    vlmax
);
  always_comb begin
    logic [31:0] scaled;
    logic [4:0]  down;
    if (!lmul[2]) begin
      scaled = 32'(VLEN) << lmul;
      down   = 5'd3 + {2'b0, sew};
    end else begin
      scaled = 32'(VLEN);
      down   = 5'd3 + {2'b0, sew} + (5'd8 - {2'b0, lmul});
    end
    scaled = scaled >> down;
    vlmax  = scaled[VLW-1:0];
  end
endmodule

// File: rtl/vcfg_unit.sv
module vcfg_unit
  import vcfg_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int VLEN = 128,
  parameter int ELEN = 64,
  localparam int VLW = $clog2(VLEN * 8) + 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_valid,
  input  logic [XLEN-1:0] avl_in,
  input  logic            rd_is_zero,
  input  logic            rs1_is_zero,
  input  logic [XLEN-1:0] vtype_in,
  output logic [VLW-1:0]  vl_out,
  output logic [XLEN-1:0] vtype_out,
  output logic [XLEN-1:0] rd_wdata
);
  localparam logic [XLEN-1:0] ILL_ONLY = {1'b1, {(XLEN-1){1'b0}}};

  logic           illegal;
  logic [VLW-1:0] vlmax;
  logic [VLW-1:0] vl_next;
  logic [XLEN-1:0] vlmax_wide;
  vcfg_fields_t   f;

  assign f = unpack_fields(vtype_in[RSV_LSB-1:0]);

  vcfg_legal_check #(.XLEN(XLEN), .ELEN(ELEN)) u_legal (
    .vtype   (vtype_in),
    .illegal (illegal)
  );

  vcfg_vlmax_calc #(.VLEN(VLEN), .VLW(VLW)) u_vlmax (
    .lmul  (f.lmul),
    .sew   (f.sew),
    .vlmax (vlmax)
  );

  assign vlmax_wide = {{(XLEN-VLW){1'b0}}, vlmax};

  always_comb begin
    if (illegal) begin
      vl_next = '0;
    end else if (rs1_is_zero && rd_is_zero) begin
      vl_next = (vl_out < vlmax) ? vl_out : vlmax;
    end else if (rs1_is_zero) begin
      vl_next = vlmax;
    end else begin
      vl_next = (avl_in < vlmax_wide) ? avl_in[VLW-1:0] : vlmax;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vl_out    <= '0;
      vtype_out <= ILL_ONLY;
      rd_wdata  <= '0;
    end else if (cfg_valid) begin
      vl_out    <= vl_next;
      vtype_out <= illegal ? ILL_ONLY : vtype_in;
      rd_wdata  <= {{(XLEN-VLW){1'b0}}, vl_next};
    end
  end
endmodule

// File: rtl/vcfg_unit_sva.sv
module vcfg_unit_sva #(
  parameter int XLEN = 32,
  parameter int VLEN = 128,
  parameter int ELEN = 64,
  parameter int VLW  = 11
) (
  input logic            clk,
  input logic            rst,
  input logic            cfg_valid,
  input logic [XLEN-1:0] avl_in,
  input logic            rd_is_zero,
  input logic            rs1_is_zero,
  input logic [XLEN-1:0] vtype_in,
  input logic [VLW-1:0]  vl_out,
  input logic [XLEN-1:0] vtype_out,
  input logic [XLEN-1:0] rd_wdata
);
  localparam logic [2:0] MAX_SEW_CODE = 3'($clog2(ELEN) - 3);

  // R5: illegal state always carries a zero length and a clean word
  p_ill_zero_vl_r5: assert property (@(posedge clk) disable iff (rst)
    vtype_out[XLEN-1] |-> (vl_out == '0) && (vtype_out[XLEN-2:0] == '0));

  // R1: too-wide element selection ends in the illegal state
  p_wide_sew_r1: assert property (@(posedge clk) disable iff (rst)
    cfg_valid && (vtype_in[5:3] > MAX_SEW_CODE) |=> vtype_out[XLEN-1]);

  // R2: reserved grouping code ends in the illegal state
  p_rsv_lmul_r2: assert property (@(posedge clk) disable iff (rst)
    cfg_valid && (vtype_in[2:0] == 3'd4) |=> vtype_out[XLEN-1]);

  // R6: keeping the current length never grows it
  p_keep_vl_r6: assert property (@(posedge clk) disable iff (rst)
    cfg_valid && rd_is_zero && rs1_is_zero |=> vl_out <= $past(vl_out));

  // R8: explicit request is an upper bound
  p_avl_bound_r8: assert property (@(posedge clk) disable iff (rst)
    cfg_valid && !rs1_is_zero |=> {{(XLEN-VLW){1'b0}}, vl_out} <= $past(avl_in));

  // R9: write-back mirrors the new length
  p_wb_match_r9: assert property (@(posedge clk) disable iff (rst)
    cfg_valid |=> rd_wdata == {{(XLEN-VLW){1'b0}}, vl_out});

  // R10: no request, no change
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !cfg_valid |=> $stable(vl_out) && $stable(vtype_out) && $stable(rd_wdata));
endmodule

bind vcfg_unit vcfg_unit_sva #(.XLEN(XLEN), .VLEN(VLEN), .ELEN(ELEN), .VLW(VLW)) u_sva (
  .clk         (clk),
  .rst         (rst),
  .cfg_valid   (cfg_valid),
  .avl_in      (avl_in),
  .rd_is_zero  (rd_is_zero),
  .rs1_is_zero (rs1_is_zero),
  .vtype_in    (vtype_in),
  .vl_out      (vl_out),
  .vtype_out   (vtype_out),
  .rd_wdata    (rd_wdata)
);

// File: tb/tb_vcfg_unit.sv
module tb_vcfg_unit;
  localparam int XLEN = 32;
  localparam int VLEN = 128;
  localparam int ELEN = 64;
  localparam int VLW  = $clog2(VLEN * 8) + 1;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [XLEN-1:0] ILL_ONLY = 32'h8000_0000;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            cfg_valid = 1'b0;
  logic [XLEN-1:0] avl_in = '0;
  logic            rd_is_zero = 1'b0;
  logic            rs1_is_zero = 1'b0;
  logic [XLEN-1:0] vtype_in = '0;
  logic [VLW-1:0]  vl_out;
  logic [XLEN-1:0] vtype_out;
  logic [XLEN-1:0] rd_wdata;

  int n_checks = 0;
  int n_fail   = 0;
  longint exp_vl = 0;
  logic [XLEN-1:0] exp_vtype = ILL_ONLY;

  always #(CLK_PERIOD/2) clk = ~clk;

  vcfg_unit #(.XLEN(XLEN), .VLEN(VLEN), .ELEN(ELEN)) dut (
    .clk(clk), .rst(rst), .cfg_valid(cfg_valid), .avl_in(avl_in),
    .rd_is_zero(rd_is_zero), .rs1_is_zero(rs1_is_zero), .vtype_in(vtype_in),
    .vl_out(vl_out), .vtype_out(vtype_out), .rd_wdata(rd_wdata)
  );

  task automatic check(input string req, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [XLEN-1:0] mk(input int sew, input int lmul);
    return XLEN'((sew << 3) | lmul);
  endfunction

  // Returns a reason tag; empty string when legal
  function automatic string why_bad(input logic [XLEN-1:0] vt);
    int sew = 8 << vt[5:3];
    int l   = int'(vt[2:0]);
    if (sew > ELEN) return "R1/R5";
    if (l == 4) return "R2/R5";
    if (l > 4 && sew * (1 << (8 - l)) > ELEN) return "R3/R5";
    if (vt[31] || vt[7:6] != 0 || vt[30:8] != 0) return "R4/R5";
    return "";
  endfunction

  function automatic longint ref_vlmax(input logic [XLEN-1:0] vt);
    int sew = 8 << vt[5:3];
    int l   = int'(vt[2:0]);
    if (l < 4) return longint'(VLEN * (1 << l) / sew);
    return longint'(VLEN / (sew * (1 << (8 - l))));
  endfunction

  task automatic run_cfg(input logic [XLEN-1:0] vt, input logic [XLEN-1:0] avl,
                         input logic rdz, input logic rs1z);
    string tag;
    longint mx;
    @(negedge clk);
    vtype_in = vt; avl_in = avl; rd_is_zero = rdz; rs1_is_zero = rs1z; cfg_valid = 1'b1;
    tag = why_bad(vt);
    if (tag != "") begin
      exp_vl = 0; exp_vtype = ILL_ONLY;
    end else begin
      mx = ref_vlmax(vt);
      if (rs1z && rdz) begin tag = "R6/R11"; exp_vl = (exp_vl < mx) ? exp_vl : mx; end
      else if (rs1z)   begin tag = "R7/R11"; exp_vl = mx; end
      else             begin tag = "R8/R11"; exp_vl = (longint'(avl) < mx) ? longint'(avl) : mx; end
      exp_vtype = vt;
    end
    @(posedge clk);
    @(negedge clk);
    cfg_valid = 1'b0;
    check({tag, " vl"}, longint'(vl_out), exp_vl);
    check({tag, " vtype"}, longint'(vtype_out), longint'(exp_vtype));
    check("R9 rd_wdata", longint'(rd_wdata), exp_vl);
  endtask

  task automatic idle_poke(input logic [XLEN-1:0] vt, input logic [XLEN-1:0] avl);
    @(negedge clk);
    cfg_valid = 1'b0; vtype_in = vt; avl_in = avl; rs1_is_zero = avl[0]; rd_is_zero = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R10 idle vl", longint'(vl_out), exp_vl);
    check("R10 idle vtype", longint'(vtype_out), longint'(exp_vtype));
    check("R10 idle rd", longint'(rd_wdata), exp_vl);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'h5EED_0A1B));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R10 reset vl", longint'(vl_out), 0);
    check("R10 reset vtype", longint'(vtype_out), longint'(ILL_ONLY));
    check("R10 reset rd", longint'(rd_wdata), 0);

    // Directed corner cases
    run_cfg(mk(0, 0), 32'd5, 1'b0, 1'b0);      // R8 below max
    run_cfg(mk(0, 0), 32'd100, 1'b0, 1'b0);    // R8 clipped to 16
    run_cfg(mk(3, 3), 32'd0, 1'b0, 1'b1);      // R7 wide, x8 -> 16
    run_cfg(mk(0, 7), 32'd0, 1'b0, 1'b1);      // R7 half -> 8
    run_cfg(mk(0, 5), 32'd9, 1'b0, 1'b0);      // R3 edge legal -> 2
    run_cfg(mk(1, 5), 32'd9, 1'b0, 1'b0);      // R3 illegal
    run_cfg(mk(0, 4), 32'd9, 1'b0, 1'b0);      // R2
    run_cfg(mk(4, 0), 32'd9, 1'b0, 1'b0);      // R1
    run_cfg(mk(0, 3), 32'd0, 1'b0, 1'b1);      // vl = 128
    run_cfg(mk(0, 0), 32'd0, 1'b1, 1'b1);      // R6 shrink to 16
    run_cfg(mk(1, 0), 32'd0, 1'b1, 1'b1);      // R6 keep 8? min(16,8)
    run_cfg(mk(2, 1), 32'd0, 1'b1, 1'b1);      // R6 keep 8
    run_cfg(mk(0, 0) | 32'h40, 32'd3, 1'b0, 1'b0);       // R4 divider
    run_cfg(mk(0, 0) | 32'h0001_0000, 32'd3, 1'b0, 1'b0); // R4 reserved
    run_cfg(mk(0, 0) | ILL_ONLY, 32'd3, 1'b0, 1'b0);      // R4 incoming flag
    run_cfg(mk(0, 0), 32'hFFFF_FFFF, 1'b0, 1'b0);         // R8 huge count
    idle_poke(mk(0, 3), 32'd77);
    idle_poke(mk(7, 4), 32'd4);

    for (int i = 0; i < 1500; i++) begin
      logic [XLEN-1:0] vt;
      logic [XLEN-1:0] avl;
      int r;
      vt = mk($urandom % 5, $urandom % 8);
      r  = $urandom % 16;
      if (r == 0) vt[7:6] = 2'($urandom % 3 + 1);
      if (r == 1) vt[8 + ($urandom % 23)] = 1'b1;
      if (r == 2) vt[31] = 1'b1;
      avl = ($urandom % 3 == 0) ? $urandom : ($urandom % 300);
      run_cfg(vt, avl, ($urandom % 4) == 0, ($urandom % 4) == 0);
      if (i % 100 == 0) idle_poke($urandom, $urandom);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule